// File: doc/BRIEF.md
# Packet Register Access Bridge

This block sits between a host byte channel and an on-chip register bus. The host sends a command as a stream of byte pairs. The first byte of a pair names a register and says whether to read or write it. The second byte carries the value to store; for a read it is a placeholder. Writes go out on the register bus at once, one handshake each, in the order they arrive. Reads are only recorded: the bridge keeps a short list of the offsets named by the latest command that contained reads.

When the host later asks for a reply, the bridge walks that list in request order. For each entry it sends the offset byte, fetches the register over the bus, and then sends the value byte. It flags the final byte of the packet. If nothing is pending, the reply is a single empty marker beat. Read requests beyond the list capacity are discarded and a sticky flag records the loss. While a reply is being built, command intake is stalled, so the list and the bus cannot change underneath it.

Top module: `pkt_reg_bridge`

## Requirements
- R1: In an address byte, bit 7 set means write and bit 7 clear means read, and bits 4..0 give the register offset; bits 6 and 5 have no effect on the access.
- R2: After the second byte of a write pair, exactly one bus write carries that pair's offset and data byte. Writes leave in arrival order, and `cmd_ready` stays low from the write's request until its handshake.
- R3: A bus request held while `bus_ready` is low keeps `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` unchanged into the next cycle.
- R4: A read pair causes no bus write, and the value of its second byte has no effect on the reply.
- R5: The first read pair of a new command empties the pending list before adding its offset; a command made only of writes leaves the list untouched.
- R6: Read pairs beyond MAX_READS (default 4) in one command are dropped and set `rd_overflow`, which then stays high until reset.
- R7: A reply for N pending offsets has 2*N beats. For each offset, in request order, the first beat is {3'b000, offset} and the second is the value returned by a bus read of that offset at reply time. `rep_last` is set only on the final beat.
- R8: A reply request with no pending offsets produces one beat with `rep_empty`=1, `rep_last`=1 and `rep_data`=8'h00.
- R9: The pending list survives a reply, so a repeated reply request returns the same offsets, each read again from the bus.
- R10: When a command ends on an address byte with no partner, that byte is discarded, and the next command starts with an address byte.
- R11: A reply beat held while `rep_ready` is low keeps `rep_valid`, `rep_data`, `rep_last` and `rep_empty` unchanged into the next cycle.
- R12: After reset, `cmd_ready`=1, `bus_valid`=0, `rep_valid`=0 and `rd_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command byte |
| cmd_last | input | 1 | Final byte of the command |
| cmd_ready | output | 1 | Bridge accepts the command byte |
| rep_req | input | 1 | One-cycle request for a reply packet |
| rep_valid | output | 1 | Reply beat present |
| rep_data | output | 8 | Reply byte |
| rep_last | output | 1 | Final beat of the reply |
| rep_empty | output | 1 | Beat is the empty-reply marker |
| rep_ready | input | 1 | Host accepts the reply beat |
| bus_valid | output | 1 | Register bus request |
| bus_write | output | 1 | Request is a write (0 means read) |
| bus_addr | output | 5 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during a read handshake |
| bus_ready | input | 1 | Register bus completes the request |
| rd_overflow | output | 1 | Sticky flag: a read request was dropped |

## Verification
The assertions check on every cycle that stalled bus requests and stalled reply beats hold steady, and that command intake is closed while a write or a reply read is on the bus. They also check that the empty marker is a lone zero beat and that the overflow flag never falls. Only the bench scenarios can show the content of the traffic. That covers the write order and values, which offsets enter the list when commands mix reads and writes, the replacement of the list by a new read command, and the dropping of surplus reads. It also covers whether reply values track writes made after the reads were queued.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

    localparam int BYTE_W  = 8;
    localparam int OFFS_W  = 5;
    localparam int DIR_BIT = 7;

    typedef struct packed {
        logic              wr;
        logic [OFFS_W-1:0] offs;
    } addr_fld_t;

    typedef struct packed {
        logic [OFFS_W-1:0] offs;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef enum logic [2:0] {
        RP_IDLE,
        RP_OFFS,
        RP_READ,
        RP_DATA,
        RP_EMPTY
    } rep_state_t;

    function automatic logic [BYTE_W-1:0] offs_byte(input logic [OFFS_W-1:0] offs);
        return BYTE_W'(offs);
    endfunction

endpackage

// File: rtl/regbridge_cmd_parser.sv
module regbridge_cmd_parser
    import regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              hold,
    output logic              wr_valid,
    output wr_req_t           wr_req,
    input  logic              wr_done,
    output logic              push,
    output logic              push_clear,
    output logic [OFFS_W-1:0] push_offs
);

    logic      phase_q;
    addr_fld_t addr_q;
    logic      fresh_q;
    logic      wr_pend_q;
    wr_req_t   wr_q;
    logic      accept;

    assign in_ready = !wr_pend_q && !hold;
    assign accept   = in_valid && in_ready;

    always_comb begin
        push       = accept && phase_q && !addr_q.wr;
        push_clear = push && fresh_q;
        push_offs  = addr_q.offs;
    end

    assign wr_valid = wr_pend_q;
    assign wr_req   = wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            addr_q    <= '0;
            fresh_q   <= 1'b1;
            wr_pend_q <= 1'b0;
            wr_q      <= '0;
        end else begin
            if (wr_pend_q && wr_done) begin
                wr_pend_q <= 1'b0;
            end
            if (accept) begin
                if (!phase_q) begin
                    addr_q.wr   <= in_data[DIR_BIT];
                    addr_q.offs <= in_data[OFFS_W-1:0];
                    phase_q     <= !in_last;
                end else begin
                    phase_q <= 1'b0;
                    if (addr_q.wr) begin
                        wr_pend_q <= 1'b1;
                        wr_q.offs <= addr_q.offs;
                        wr_q.data <= in_data;
                    end
                end
                if (push) begin
                    fresh_q <= 1'b0;
                end
                if (in_last) begin
                    fresh_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/regbridge_read_list.sv
module regbridge_read_list
    import regbridge_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              push_clear,
    input  logic [OFFS_W-1:0] push_offs,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [OFFS_W-1:0] rd_offs,
    output logic [CNT_W-1:0]  cnt,
    output logic              overflow
);

    logic [OFFS_W-1:0] ent_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              has_room;

    assign has_room = cnt_q < CNT_W'(DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic sel;
        assign sel = push && (push_clear ? (g == 0) : (cnt_q == CNT_W'(g)));
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (sel) begin
                ent_q[g] <= push_offs;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (push) begin
            if (push_clear) begin
                cnt_q <= CNT_W'(1);
            end else if (has_room) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign rd_offs  = ent_q[rd_idx];
    assign cnt      = cnt_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/regbridge_reply.sv
module regbridge_reply
    import regbridge_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rep_req,
    input  logic              wr_busy,
    input  logic [CNT_W-1:0]  list_cnt,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic              hold,
    output logic              bus_rd_valid,
    output logic [OFFS_W-1:0] bus_rd_addr,
    input  logic              bus_ready,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              rep_valid,
    output logic [BYTE_W-1:0] rep_data,
    output logic              rep_last,
    output logic              rep_empty,
    input  logic              rep_ready
);

    rep_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pend_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              start;
    logic              last_pair;

    assign start     = pend_q && !wr_busy && (state_q == RP_IDLE);
    assign last_pair = (CNT_W'(idx_q) + CNT_W'(1)) == list_cnt;
    assign hold      = pend_q || (state_q != RP_IDLE);
    assign rd_idx    = idx_q;
    assign bus_rd_addr = rd_offs;

    always_comb begin
        rep_valid    = 1'b0;
        rep_data     = '0;
        rep_last     = 1'b0;
        rep_empty    = 1'b0;
        bus_rd_valid = 1'b0;
        case (state_q)
            RP_OFFS: begin
                rep_valid = 1'b1;
                rep_data  = offs_byte(rd_offs);
            end
            RP_READ: bus_rd_valid = 1'b1;
            RP_DATA: begin
                rep_valid = 1'b1;
                rep_data  = rdata_q;
                rep_last  = last_pair;
            end
            RP_EMPTY: begin
                rep_valid = 1'b1;
                rep_last  = 1'b1;
                rep_empty = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RP_IDLE;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                pend_q <= 1'b0;
            end
            if (rep_req) begin
                pend_q <= 1'b1;
            end
            case (state_q)
                RP_IDLE: begin
                    if (start) begin
                        idx_q   <= '0;
                        state_q <= (list_cnt == '0) ? RP_EMPTY : RP_OFFS;
                    end
                end
                RP_OFFS: begin
                    if (rep_ready) state_q <= RP_READ;
                end
                RP_READ: begin
                    if (bus_ready) begin
                        rdata_q <= bus_rdata;
                        state_q <= RP_DATA;
                    end
                end
                RP_DATA: begin
                    if (rep_ready) begin
                        if (last_pair) begin
                            state_q <= RP_IDLE;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= RP_OFFS;
                        end
                    end
                end
                RP_EMPTY: begin
                    if (rep_ready) state_q <= RP_IDLE;
                end
                default: state_q <= RP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pkt_reg_bridge.sv
module pkt_reg_bridge
    import regbridge_pkg::*;
#(
    parameter int MAX_READS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_data,
    input  logic              cmd_last,
    output logic              cmd_ready,
    input  logic              rep_req,
    output logic              rep_valid,
    output logic [7:0]        rep_data,
    output logic              rep_last,
    output logic              rep_empty,
    input  logic              rep_ready,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [4:0]        bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic              rd_overflow
);

    localparam int CNT_W = $clog2(MAX_READS + 1);
    localparam int IDX_W = (MAX_READS > 1) ? $clog2(MAX_READS) : 1;

    logic              hold;
    logic              wr_valid;
    wr_req_t           wr_req;
    logic              wr_done;
    logic              push;
    logic              push_clear;
    logic [OFFS_W-1:0] push_offs;
    logic [IDX_W-1:0]  rd_idx;
    logic [OFFS_W-1:0] rd_offs;
    logic [CNT_W-1:0]  list_cnt;
    logic              bus_rd_valid;
    logic [OFFS_W-1:0] bus_rd_addr;

    regbridge_cmd_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (cmd_valid),
        .in_data    (cmd_data),
        .in_last    (cmd_last),
        .in_ready   (cmd_ready),
        .hold       (hold),
        .wr_valid   (wr_valid),
        .wr_req     (wr_req),
        .wr_done    (wr_done),
        .push       (push),
        .push_clear (push_clear),
        .push_offs  (push_offs)
    );

    regbridge_read_list #(.DEPTH(MAX_READS)) u_list (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_clear (push_clear),
        .push_offs  (push_offs),
        .rd_idx     (rd_idx),
        .rd_offs    (rd_offs),
        .cnt        (list_cnt),
        .overflow   (rd_overflow)
    );

    regbridge_reply #(.DEPTH(MAX_READS)) u_reply (
        .clk          (clk),
        .rst          (rst),
        .rep_req      (rep_req),
        .wr_busy      (wr_valid),
        .list_cnt     (list_cnt),
        .rd_idx       (rd_idx),
        .rd_offs      (rd_offs),
        .hold         (hold),
        .bus_rd_valid (bus_rd_valid),
        .bus_rd_addr  (bus_rd_addr),
        .bus_ready    (bus_ready),
        .bus_rdata    (bus_rdata),
        .rep_valid    (rep_valid),
        .rep_data     (rep_data),
        .rep_last     (rep_last),
        .rep_empty    (rep_empty),
        .rep_ready    (rep_ready)
    );

    // Writes and reply reads never overlap: a reply starts only once the
    // pending write has drained, and intake stays closed until it ends.
    assign bus_valid = wr_valid || bus_rd_valid;
    assign bus_write = wr_valid;
    assign bus_addr  = wr_valid ? wr_req.offs : bus_rd_addr;
    assign bus_wdata = wr_valid ? wr_req.data : '0;
    assign wr_done   = wr_valid && bus_ready;

endmodule

// File: rtl/pkt_reg_bridge_chk.sv
module pkt_reg_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_ready,
    input logic       rep_valid,
    input logic [7:0] rep_data,
    input logic       rep_last,
    input logic       rep_empty,
    input logic       rep_ready,
    input logic       bus_valid,
    input logic       bus_write,
    input logic [4:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_ready,
    input logic       rd_overflow
);

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R3

    AST_REP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rep_valid && !rep_ready |=> rep_valid && $stable(rep_data) && $stable(rep_last) && $stable(rep_empty)); // R11

    AST_WRITE_STALLS_CMD: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_write |-> !cmd_ready); // R2

    AST_READ_IN_REPLY: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_write |-> !cmd_ready && !rep_valid); // R7

    AST_EMPTY_BEAT: assert property (@(posedge clk) disable iff (rst)
        rep_valid && rep_empty |-> rep_last && (rep_data == 8'h00)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rd_overflow |=> rd_overflow); // R6

endmodule

bind pkt_reg_bridge pkt_reg_bridge_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_ready   (cmd_ready),
    .rep_valid   (rep_valid),
    .rep_data    (rep_data),
    .rep_last    (rep_last),
    .rep_empty   (rep_empty),
    .rep_ready   (rep_ready),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ready   (bus_ready),
    .rd_overflow (rd_overflow)
);

// File: tb/pkt_reg_bridge_bench.sv
module pkt_reg_bridge_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_last = 1'b0;
    logic       cmd_ready;
    logic       rep_req = 1'b0;
    logic       rep_valid;
    logic [7:0] rep_data;
    logic       rep_last;
    logic       rep_empty;
    logic       rep_ready = 1'b0;
    logic       bus_valid;
    logic       bus_write;
    logic [4:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       bus_ready = 1'b0;
    logic       rd_overflow;

    pkt_reg_bridge u_pkt_reg_bridge (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // register file on the far side of the bus, and the bench's expectation
    logic [7:0] mem [32];
    logic [7:0] exp_mem [32];
    assign bus_rdata = mem[bus_addr];

    // observed writes and reply beats
    logic [4:0] wl_addr [64];
    logic [7:0] wl_data [64];
    int         wl_n = 0;
    logic [7:0] rb [64];
    logic       re [64];
    int         rn = 0;
    bit         rep_done = 1'b0;
    bit         rep_last_early = 1'b0;

    // expected state
    logic [4:0] ex_wa [64];
    logic [7:0] ex_wd [64];
    int         ex_wn = 0;
    logic [4:0] ex_offs [4];
    int         ex_n = 0;
    bit         ex_ovf = 1'b0;

    logic [7:0] ca [16];
    logic [7:0] cd [16];

    logic       pb_valid = 1'b0, pb_ready = 1'b0, pb_write = 1'b0;
    logic [4:0] pb_addr = '0;
    logic [7:0] pb_wdata = '0;
    logic       pr_valid = 1'b0, pr_ready = 1'b0, pr_last = 1'b0, pr_empty = 1'b0;
    logic [7:0] pr_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // bus and reply responder; readies are chosen first, then the
    // handshake for the coming edge is recorded
    always @(negedge clk) begin
        if (!rst) begin
            bus_ready = ($urandom % 4) != 0;
            rep_ready = ($urandom % 3) != 0;
            if (pb_valid && !pb_ready)   // R3
                chk(bus_valid && bus_write == pb_write && bus_addr == pb_addr && bus_wdata == pb_wdata,
                    "R3 bus hold", {bus_valid, bus_addr}, {pb_valid, pb_addr});
            if (pr_valid && !pr_ready)   // R11
                chk(rep_valid && rep_data == pr_data && rep_last == pr_last && rep_empty == pr_empty,
                    "R11 reply hold", {rep_valid, rep_data}, {pr_valid, pr_data});
            if (bus_valid && bus_ready && bus_write) begin
                mem[bus_addr] = bus_wdata;
                wl_addr[wl_n] = bus_addr;
                wl_data[wl_n] = bus_wdata;
                wl_n++;
            end
            if (rep_valid && rep_ready) begin
                rb[rn] = rep_data;
                re[rn] = rep_empty;
                rn++;
                if (rep_last) rep_done = 1'b1;
            end
            pb_valid = bus_valid; pb_ready = bus_ready; pb_write = bus_write;
            pb_addr = bus_addr; pb_wdata = bus_wdata;
            pr_valid = rep_valid; pr_ready = rep_ready; pr_last = rep_last;
            pr_empty = rep_empty; pr_data = rep_data;
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit l);
        cmd_valid = 1'b1;
        cmd_data  = b;
        cmd_last  = l;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_last  = 1'b0;
    endtask

    // send n pairs from ca/cd, optionally followed by a lone address byte
    task automatic send_cmd(input int n, input bit lone, input logic [7:0] lone_b, input string tag);
        bit fresh = 1'b1;
        wl_n  = 0;
        ex_wn = 0;
        for (int i = 0; i < n; i++) begin
            if (ca[i][7]) begin
                exp_mem[ca[i][4:0]] = cd[i];
                ex_wa[ex_wn] = ca[i][4:0];
                ex_wd[ex_wn] = cd[i];
                ex_wn++;
            end else begin
                if (fresh) begin ex_n = 0; fresh = 1'b0; end
                if (ex_n < 4) begin ex_offs[ex_n] = ca[i][4:0]; ex_n++; end
                else ex_ovf = 1'b1;
            end
            send_byte(ca[i], 1'b0);
            send_byte(cd[i], !lone && (i == n - 1));
        end
        if (lone) send_byte(lone_b, 1'b1);
        while (bus_valid) @(negedge clk);
        chk(wl_n == ex_wn, {tag, " R2 write count"}, wl_n, ex_wn);
        for (int i = 0; i < ex_wn && i < wl_n; i++)
            chk(wl_addr[i] == ex_wa[i] && wl_data[i] == ex_wd[i], {tag, " R2 write"},
                {wl_addr[i], wl_data[i]}, {ex_wa[i], ex_wd[i]});
        chk(rd_overflow == ex_ovf, {tag, " R6 overflow"}, rd_overflow, ex_ovf);
    endtask

    task automatic do_reply(input string tag);
        rn = 0;
        rep_done = 1'b0;
        rep_req = 1'b1;
        @(negedge clk);
        rep_req = 1'b0;
        while (!rep_done) @(negedge clk);
        if (ex_n == 0) begin
            chk(rn == 1 && re[0] == 1'b1 && rb[0] == 8'h00, {tag, " R8 empty reply"},
                {rn[7:0], 7'd0, re[0], rb[0]}, {8'd1, 8'd1, 8'h00});
        end else begin
            chk(rn == 2 * ex_n, {tag, " R7 reply length"}, rn, 2 * ex_n);
            for (int i = 0; i < ex_n && 2 * i + 1 < rn; i++) begin
                chk(rb[2*i] == {3'b000, ex_offs[i]}, {tag, " R7 offset byte"}, rb[2*i], {3'b000, ex_offs[i]});
                chk(rb[2*i+1] == exp_mem[ex_offs[i]], {tag, " R7 data byte"}, rb[2*i+1], exp_mem[ex_offs[i]]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin
            mem[i] = 8'(i * 37 + 5);
            exp_mem[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(cmd_ready == 1'b1, "R12 cmd_ready", cmd_ready, 1);
        chk(bus_valid == 1'b0, "R12 bus_valid", bus_valid, 0);
        chk(rep_valid == 1'b0, "R12 rep_valid", rep_valid, 0);
        chk(rd_overflow == 1'b0, "R12 rd_overflow", rd_overflow, 0);
        rst = 1'b0;
        @(negedge clk);

        // R8: nothing pending yet
        do_reply("R8");

        // R1: bits 6:5 set on both a write and a read; R4: nonzero read filler
        ca[0] = 8'hE3; cd[0] = 8'h5A;
        ca[1] = 8'h6A; cd[1] = 8'h77;
        send_cmd(2, 1'b0, 8'h00, "R1");
        chk(mem[3] == 8'h5A, "R1 write reached offset 3", mem[3], 8'h5A);
        do_reply("R4");

        // R5: write-only command keeps the list; R9: reads are redone
        ca[0] = 8'h8A; cd[0] = 8'h3C;
        send_cmd(1, 1'b0, 8'h00, "R5 keep");
        do_reply("R9 first");
        do_reply("R9 repeat");

        // R10: lone address byte ends a command
        send_cmd(0, 1'b1, 8'h81, "R10 lone");
        ca[0] = 8'h82; cd[0] = 8'h11;
        send_cmd(1, 1'b0, 8'h00, "R10 next");
        chk(wl_n == 1 && wl_addr[0] == 5'd2, "R10 realigned", wl_addr[0], 2);

        // R5: new read command replaces the list
        ca[0] = 8'h05; cd[0] = 8'h00;
        ca[1] = 8'h81; cd[1] = 8'h44;
        ca[2] = 8'h07; cd[2] = 8'h00;
        send_cmd(3, 1'b0, 8'h00, "R5 replace");
        do_reply("R5 replace");

        // R6: six reads, two dropped
        for (int i = 0; i < 6; i++) begin ca[i] = 8'(i + 16); cd[i] = 8'h00; end
        send_cmd(6, 1'b0, 8'h00, "R6");
        chk(rd_overflow == 1'b1, "R6 flag set", rd_overflow, 1);
        do_reply("R6");

        // random mix
        for (int it = 0; it < 150; it++) begin
            int n = 1 + ($urandom % 8);
            for (int i = 0; i < n; i++) begin
                ca[i] = 8'($urandom);
                cd[i] = ca[i][7] ? 8'($urandom) : 8'h00;
            end
            send_cmd(n, 1'b0, 8'h00, "rand");
            if (($urandom % 2) == 0) do_reply("rand");
        end
        do_reply("final");

        finish_run();
    end

endmodule